// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block turns a step command stream into the four active-low winding enables of a two-phase stepper motor. Each falling edge on the step input moves the rotor position by one increment. A direction input picks whether the phase pattern is walked upward or downward. A mode input picks between an eight-position half-step pattern and a four-position full-step pattern, which uses only the states with two windings on. Two position flags report which quadrant of the half-step cycle the sequencer is in. An external driver can use them when this block serves only as a phase encoder.

All control inputs are asynchronous to the system clock. They are brought in through a two-flop synchroniser, and the step edge is detected after it. The clock must therefore run fast enough to sample each level of the shortest accepted step pulse (800 ns) at least twice. An asynchronous power-on reset parks the sequencer at a fixed home position with every winding off. A supply-good hook parks it there again whenever the supply sags. An inhibit input switches every winding off but keeps the stored position. The interface carries no data stream, so every pin is a plain level with no handshake.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position changes only on a high-to-low transition of `step_in`. A rising edge or a steady level leaves `phase_n` and `pos_flag` unchanged.
- R2: With `full_step` low, each accepted edge moves the position index p by one. `phase_n` bits are {b2,b1,a2,a1} and active low, and p = 0..7 drives 1110, 1010, 1011, 1001, 1101, 0101, 0111, 0110. Enables a1/a2 are never low together, and neither are b1/b2.
- R3: With `dir_fwd` high the index increases modulo 8. With it low the index decreases modulo 8.
- R4: With `full_step` high and an odd index (two windings on), each accepted edge moves the index by two in the selected direction.
- R5: With `full_step` high and an even index (one winding on), the next accepted edge moves the index by one, to the adjacent two-winding state in the selected direction.
- R6: After reset is released with `supply_ok` high, and within four clock cycles, the block shows home index 0: `phase_n` = 1110 and `pos_flag` = 00. While `rst_n` is low, `phase_n` is 1111.
- R7: While `inhibit` is high, `phase_n` is 1111. Step edges are still counted and `pos_flag` follows the index. After release, `phase_n` shows the current index.
- R8: While `supply_ok` is low, `phase_n` is 1111, the index is forced to home, and step edges are ignored. This holds even when a step edge arrives in the same cycle that `supply_ok` falls. After recovery, stepping restarts from index 0.
- R9: `pos_flag` = {p[2], p[2]^p[1]}, a Gray-coded quadrant of the index.
- R10: Outputs show the new position no later than four clock cycles after the step falling edge is presented at the pins. `dir_fwd` and `full_step` need the same setup as `step_in` and zero hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| step_in | input | 1 | Step command; the falling edge advances the position |
| dir_fwd | input | 1 | High walks the index upward, low walks it downward |
| full_step | input | 1 | Low selects half-step, high selects full-step |
| inhibit | input | 1 | High switches all windings off while keeping the position |
| supply_ok | input | 1 | Low-supply hook; low parks the sequencer at home |
| phase_n | output | 4 | Active-low winding enables {b2,b1,a2,a1} |
| pos_flag | output | 2 | Gray-coded quadrant of the half-step index |

## Verification
Two pairs of events can fall in the same cycle. First, a step falling edge can reach the state register in the very cycle the synchronised supply-good level drops. The bench provokes this by lowering `step_in` and `supply_ok` on the same clock edge, so both pass through the same synchroniser stages together. It then judges that the windings are off, that the step was not counted, and that stepping restarts from index 0 once supply returns. Second, a mode or direction change can arrive together with the edge it governs. The sweep changes `full_step` and `dir_fwd` on every trial only a few cycles before the edge. It compares each result with an index model that the bench computes arithmetically.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;

  localparam int POS_W  = 3;
  localparam int COILS  = 4;
  localparam int FLAG_W = 2;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [COILS-1:0]  coil_t;
  typedef logic [FLAG_W-1:0] flag_t;

  localparam pos_t  HOME_POS = '0;
  localparam coil_t ALL_OFF  = '1;

  typedef struct packed {
    logic step;
    logic dir_fwd;
    logic full;
    logic inhibit;
    logic supply_ok;
  } ctl_t;

  // Active-low enables {b2,b1,a2,a1} for each half-step index.
  function automatic coil_t coil_drive_n(pos_t p);
    coil_t d;
    case (p)
      3'd0:    d = 4'b1110;
      3'd1:    d = 4'b1010;
      3'd2:    d = 4'b1011;
      3'd3:    d = 4'b1001;
      3'd4:    d = 4'b1101;
      3'd5:    d = 4'b0101;
      3'd6:    d = 4'b0111;
      default: d = 4'b0110;
    endcase
    return d;
  endfunction

  function automatic flag_t quadrant_gray(pos_t p);
    return {p[2], p[2] ^ p[1]};
  endfunction

endpackage

// File: rtl/stepper_in_sync.sv
module stepper_in_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[LAST];

  initial begin
    assert (STAGES >= 2) else $error("synchroniser needs at least two stages");
  end
endmodule

// File: rtl/stepper_fall_det.sv
module stepper_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign fall = level_d & ~level;

  // R1: a single falling edge yields a one-cycle pulse
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/stepper_pos_reg.sv
module stepper_pos_reg
  import stepper_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic dir_fwd,
  input  logic full,
  input  logic supply_ok,
  output pos_t pos
);
  pos_t mag;
  pos_t next_pos;

  always_comb begin
    mag      = (full && pos[0]) ? pos_t'(2) : pos_t'(1);
    next_pos = dir_fwd ? pos + mag : pos - mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos <= HOME_POS;
    else if (!supply_ok) pos <= HOME_POS;
    else if (adv)        pos <= next_pos;
  end

  assert_hold_without_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && supply_ok) |=> $stable(pos));

  assert_edge_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && supply_ok) |=> (pos != $past(pos)));

  assert_full_lands_two_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && full && supply_ok) |=> pos[0]);

  assert_low_supply_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (pos == HOME_POS));
endmodule

// File: rtl/stepper_out_dec.sv
module stepper_out_dec
  import stepper_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pos_t  pos,
  input  logic  blank,
  output coil_t phase_n,
  output flag_t pos_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_n  <= ALL_OFF;
      pos_flag <= quadrant_gray(HOME_POS);
    end else begin
      phase_n  <= blank ? ALL_OFF : coil_drive_n(pos);
      pos_flag <= quadrant_gray(pos);
    end
  end

  assert_blank_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (phase_n == ALL_OFF));
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_fwd,
  input  logic       full_step,
  input  logic       inhibit,
  input  logic       supply_ok,
  output logic [3:0] phase_n,
  output logic [1:0] pos_flag
);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t raw_ctl;
  ctl_t syn_ctl;
  logic step_fall;
  pos_t pos;
  logic blank;

  assign raw_ctl = '{step: step_in, dir_fwd: dir_fwd, full: full_step,
                     inhibit: inhibit, supply_ok: supply_ok};

  stepper_in_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_ctl),
    .sync_out (syn_ctl)
  );

  stepper_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .level (syn_ctl.step),
    .fall  (step_fall)
  );

  stepper_pos_reg u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (step_fall),
    .dir_fwd   (syn_ctl.dir_fwd),
    .full      (syn_ctl.full),
    .supply_ok (syn_ctl.supply_ok),
    .pos       (pos)
  );

  assign blank = syn_ctl.inhibit | ~syn_ctl.supply_ok;

  stepper_out_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos      (pos),
    .blank    (blank),
    .phase_n  (phase_n),
    .pos_flag (pos_flag)
  );

  assert_winding_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_n[0] | phase_n[1]) && (phase_n[2] | phase_n[3]));

  assert_at_most_two_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~phase_n) <= 2);
endmodule

// File: tb/stepper_phase_seq_tb_top.sv
module stepper_phase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_fwd = 1'b1;
  logic       full_step = 1'b0;
  logic       inhibit = 1'b0;
  logic       supply_ok = 1'b1;
  logic [3:0] phase_n;
  logic [1:0] pos_flag;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stepper_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_fwd(dir_fwd),
    .full_step(full_step), .inhibit(inhibit), .supply_ok(supply_ok),
    .phase_n(phase_n), .pos_flag(pos_flag)
  );

  // Coil centres on the 8-position circle: a1=0, b1=2, a2=4, b2=6.
  function automatic logic [3:0] exp_phase(int p);
    int centre [4] = '{0, 4, 2, 6};
    logic [3:0] r;
    for (int c = 0; c < 4; c++) begin
      int d = (p - centre[c] + 8) % 8;
      r[c] = !(d == 0 || d == 1 || d == 7);
    end
    return r;
  endfunction

  function automatic logic [1:0] exp_flag(int p);
    int q = p / 4;
    int h = (p / 2) % 2;
    return {q[0], q[0] ^ h[0]};
  endfunction

  function automatic int next_model(int p, bit full, bit fwd);
    int m = (full && (p % 2 == 1)) ? 2 : 1;
    return fwd ? (p + m) % 8 : (p - m + 8) % 8;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    logic [3:0] ep = inhibit ? 4'b1111 : exp_phase(model);
    check(req, {phase_n, pos_flag}, {ep, exp_flag(model)});
  endtask

  task automatic do_step(bit full, bit fwd, string req);
    @(negedge clk);
    full_step = full;
    dir_fwd   = fwd;
    repeat (3) @(negedge clk);
    step_in = 1'b1;
    repeat (5) @(negedge clk);
    check_outputs("R1 rising edge ignored");
    step_in = 1'b0;
    model = next_model(model, full, fwd);
    repeat (4) @(negedge clk);
    check_outputs({req, " R10"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset blanked", {phase_n, pos_flag}, {4'b1111, 2'b00});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 home after reset", {phase_n, pos_flag}, {4'b1110, 2'b00});

    // Exhaustive half-step walks both ways (R2, R3, R9).
    for (int i = 0; i < 8; i++) do_step(1'b0, 1'b1, "R2 R9 half fwd");
    for (int i = 0; i < 9; i++) do_step(1'b0, 1'b0, "R3 half back");

    // Mixed-mode sweep: mode and direction change right before each edge.
    for (int t = 0; t < 64; t++) begin
      bit full = t[0];
      bit fwd  = t[1] ^ t[4];
      bit odd  = (model % 2 == 1);
      if (full && odd)       do_step(1'b1, fwd, "R4 full from two-on");
      else if (full && !odd) do_step(1'b1, fwd, "R5 full from one-on");
      else                   do_step(1'b0, fwd, "R2 half sweep");
      if (t[2] & t[3]) do_step(1'b0, ~fwd, "R3 half reverse");
    end

    // Steady level: no change with step held low.
    repeat (10) @(negedge clk);
    check_outputs("R1 steady level");

    // Inhibit keeps counting.
    inhibit = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R7 inhibit blanks");
    do_step(1'b0, 1'b1, "R7 count while inhibited");
    do_step(1'b1, 1'b1, "R7 R9 flags while inhibited");
    inhibit = 1'b0;
    repeat (4) @(negedge clk);
    check_outputs("R7 release shows position");

    // Supply drop coinciding with a step falling edge.
    if (model == 0) do_step(1'b0, 1'b1, "R2 move off home");
    @(negedge clk);
    step_in = 1'b1;
    repeat (5) @(negedge clk);
    step_in = 1'b0;
    supply_ok = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 low supply blanks", {phase_n, pos_flag}, {4'b1111, 2'b00});
    step_in = 1'b1;
    repeat (5) @(negedge clk);
    step_in = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    model = 0;
    repeat (4) @(negedge clk);
    check("R8 restart from home", {phase_n, pos_flag}, {4'b1110, 2'b00});
    do_step(1'b1, 1'b0, "R8 R5 first step after recovery");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule